// File: doc/BRIEF.md
# Register Bus Access Sequencer

The sequencer turns single commands from a request/ready port into correctly timed transactions on a management register bus. That bus has a 16-bit address, 32-bit write and read data, separate write and read strobes, and a read-data-valid return. Every strobe is stretched to a minimum hold. Address and write data stay stable for the whole strobe. After each transaction the bus is forced idle before the next one starts.

Only one command is outstanding at a time. A command is taken only while the sequencer is idle. A write holds its strobe for the minimum hold and then ends. A read holds its strobe until the valid return is seen, and its data is captured in the cycle where valid is high. If valid never arrives, a timeout ends the read with an error. Each transaction ends with a one-cycle done pulse on the command side. For reads, the pulse carries the captured data.

Top module: `regbus_seq`

## Requirements
- R1: `req_ready_o` is high only while no transaction is in progress and both strobes are low. A command is accepted only on a clock edge where `req_valid_i` and `req_ready_o` are both high, and without an accepted command both strobes stay low.
- R2: A write drives `bus_write_o` for exactly MIN_HOLD consecutive cycles (default 2). The strobe rises in the cycle after acceptance.
- R3: The write and read strobes are never high in the same cycle. After any strobe falls, both strobes stay low for at least GAP_CYC cycles (default 1) before either rises again, whatever the mix of reads and writes.
- R4: A read raises `bus_read_o` in the cycle after acceptance. It keeps the strobe high through the first cycle in which `bus_rvalid_i` has been seen, and for at least MIN_HOLD cycles. The strobe drops in the next cycle. For a valid return L cycles after strobe start (cycle 0 = first strobe cycle), the strobe length is max(L, MIN_HOLD-1)+1.
- R5: The read data returned is `bus_rdata_i` as sampled in the first strobe cycle with `bus_rvalid_i` high.
- R6: `done_o` is a one-cycle pulse in the first cycle after the strobe falls. On a successful read, `done_err_o` is 0 and `done_rdata_o` holds the captured data. On a write, `done_err_o` is 0 and `done_rdata_o` is all zeros.
- R7: A read that sees no valid return during TIMEOUT strobe cycles ends with a strobe of exactly TIMEOUT cycles. Its done pulse then carries `done_err_o`=1 and `done_rdata_o` all ones. A valid return in strobe cycle TIMEOUT-1 still succeeds.
- R8: While `rst_ni` is low, both strobes, `done_o` and `done_err_o` are low and `req_ready_o` is high. This holds even when reset arrives in the middle of a transaction.
- R9: During a strobe, `bus_addr_o` equals the accepted address. During a write strobe, `bus_wdata_o` equals the accepted write data. Both stay stable even if the request inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Command request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Command address |
| req_wdata_i | input | DATA_W | Command write data |
| req_ready_o | output | 1 | Sequencer idle, command can be taken |
| done_o | output | 1 | One-cycle transaction end pulse |
| done_err_o | output | 1 | Read timed out |
| done_rdata_o | output | DATA_W | Read data (all ones on timeout, zero for writes) |
| bus_write_o | output | 1 | Bus write strobe |
| bus_read_o | output | 1 | Bus read strobe |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rvalid_i | input | 1 | Bus read data valid |
| bus_rdata_i | input | DATA_W | Bus read data |

## Verification
The bench builds the block with TIMEOUT=6, MIN_HOLD=2 and GAP_CYC=1. It sweeps the valid-return latency over every value from the strobe's first cycle to beyond the timeout, and also covers a read where valid never arrives. The short timeout puts the minimum-hold stretch, the last cycle that still succeeds and the timeout path side by side in one short sweep. Interleaved write and read mixes check the forced idle between transactions, and a reset in the middle of a read checks recovery.

// File: rtl/regbus_seq_pkg.sv
package regbus_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/regbus_seq_cmd.sv
module regbus_seq_cmd #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      write_o <= write_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/regbus_seq_fsm.sv
module regbus_seq_fsm
  import regbus_seq_pkg::*;
#(
  parameter int MIN_HOLD = 2,
  parameter int GAP_CYC  = 1,
  parameter int TIMEOUT  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic start_write_i,
  input  logic rvalid_i,
  output logic ready_o,
  output logic wr_stb_o,
  output logic rd_stb_o,
  output logic finish_o,
  output logic timeout_o,
  output logic capture_o
);
  localparam int MAXC  = (TIMEOUT > MIN_HOLD) ? ((TIMEOUT > GAP_CYC) ? TIMEOUT : GAP_CYC)
                                              : ((MIN_HOLD > GAP_CYC) ? MIN_HOLD : GAP_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(MIN_HOLD - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LAST   = CNT_W'(TIMEOUT - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             got_q, got_d;
  logic             hit;

  assign hit       = rvalid_i | got_q;
  assign ready_o   = (state_q == ST_IDLE);
  assign wr_stb_o  = (state_q == ST_WR);
  assign rd_stb_o  = (state_q == ST_RD);
  assign capture_o = rd_stb_o & rvalid_i & ~got_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    got_d     = got_q;
    finish_o  = 1'b0;
    timeout_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = start_write_i ? ST_WR : ST_RD;
          cnt_d   = '0;
          got_d   = 1'b0;
        end
      end
      ST_WR: begin
        if (cnt_q == HOLD_LAST) begin
          state_d  = ST_GAP;
          cnt_d    = '0;
          finish_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RD: begin
        if (hit && cnt_q >= HOLD_LAST) begin
          state_d  = ST_GAP;
          cnt_d    = '0;
          finish_o = 1'b1;
        end else if (!hit && cnt_q == TO_LAST) begin
          state_d   = ST_GAP;
          cnt_d     = '0;
          finish_o  = 1'b1;
          timeout_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
          got_d = hit;
        end
      end
      ST_GAP: begin
        if (cnt_q == GAP_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      got_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      got_q   <= got_d;
    end
  end
endmodule

// File: rtl/regbus_seq_rsp.sv
module regbus_seq_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              finish_i,
  input  logic              timeout_i,
  input  logic              is_read_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] ret_d;

  always_comb begin
    if (timeout_i)       ret_d = '1;
    else if (!is_read_i) ret_d = '0;
    else if (capture_i)  ret_d = rdata_i;
    else                 ret_d = cap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (capture_i) cap_q <= rdata_i;
      done_o <= finish_i;
      if (finish_i) begin
        err_o   <= timeout_i;
        rdata_o <= ret_d;
      end else begin
        err_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regbus_seq.sv
module regbus_seq #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int MIN_HOLD = 2,
  parameter int GAP_CYC  = 1,
  parameter int TIMEOUT  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              done_err_o,
  output logic [DATA_W-1:0] done_rdata_o,
  output logic              bus_write_o,
  output logic              bus_read_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_rvalid_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  logic start, cmd_write, finish, timeout, capture;

  assign start = req_valid_i & req_ready_o;

  regbus_seq_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .write_o (cmd_write),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o)
  );

  regbus_seq_fsm #(.MIN_HOLD(MIN_HOLD), .GAP_CYC(GAP_CYC), .TIMEOUT(TIMEOUT)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .start_write_i (req_write_i),
    .rvalid_i      (bus_rvalid_i),
    .ready_o       (req_ready_o),
    .wr_stb_o      (bus_write_o),
    .rd_stb_o      (bus_read_o),
    .finish_o      (finish),
    .timeout_o     (timeout),
    .capture_o     (capture)
  );

  regbus_seq_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .finish_i  (finish),
    .timeout_i (timeout),
    .is_read_i (~cmd_write),
    .rdata_i   (bus_rdata_i),
    .done_o    (done_o),
    .err_o     (done_err_o),
    .rdata_o   (done_rdata_o)
  );
endmodule

// File: rtl/regbus_seq_chk.sv
module regbus_seq_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              done_err_o,
  input logic [DATA_W-1:0] done_rdata_o,
  input logic              bus_write_o,
  input logic              bus_read_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o
);
  int rd_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rd_run_q <= 0;
    else if (bus_read_o) rd_run_q <= (rd_run_q < TIMEOUT + 1) ? rd_run_q + 1 : rd_run_q;
    else                 rd_run_q <= 0;
  end

  p_ready_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_write_o && !bus_read_o);

  p_wr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_write_o) |-> $past(bus_write_o, 2));

  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_write_o && bus_read_o));

  p_wr_after_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_write_o) |-> !$past(bus_read_o));

  p_rd_after_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_read_o) |-> !$past(bus_write_o));

  p_rd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_read_o) |-> $past(bus_read_o, 2));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_stb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bus_write_o) || $fell(bus_read_o)) |-> done_o);

  p_err_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_err_o) |-> (done_rdata_o == '1));

  p_rd_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_run_q <= TIMEOUT);

  p_addr_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_write_o && $past(bus_write_o)) || (bus_read_o && $past(bus_read_o)))
      |-> $stable(bus_addr_o));

  p_wdata_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_write_o && $past(bus_write_o)) |-> $stable(bus_wdata_o));
endmodule

bind regbus_seq regbus_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .done_o       (done_o),
  .done_err_o   (done_err_o),
  .done_rdata_o (done_rdata_o),
  .bus_write_o  (bus_write_o),
  .bus_read_o   (bus_read_o),
  .bus_addr_o   (bus_addr_o),
  .bus_wdata_o  (bus_wdata_o)
);

// File: tb/regbus_seq_tb_top.sv
`timescale 1ns/100ps
module regbus_seq_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int HOLD = 2;
  localparam int GAP = 1;
  localparam int TO = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done, done_err;
  logic [DW-1:0] done_rdata;
  logic bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_rvalid = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  regbus_seq #(.ADDR_W(AW), .DATA_W(DW), .MIN_HOLD(HOLD), .GAP_CYC(GAP), .TIMEOUT(TO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .done_o(done), .done_err_o(done_err), .done_rdata_o(done_rdata),
    .bus_write_o(bus_wr), .bus_read_o(bus_rd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rvalid_i(bus_rvalid), .bus_rdata_i(bus_rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int n);
    return 32'h5A00_0000 ^ (32'(n) * 32'h0101_0137);
  endfunction

  // lat < 0 : valid never returned
  task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int lat, input logic [DW-1:0] rp);
    int k = 0;
    int len = 0;
    int g = 0;
    int exp_len;
    bit timed_out;
    bit bad_stable = 0;
    bit bad_ready = 0;
    bit early_done = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    while (!done && k < 64) begin
      if (bus_wr || bus_rd) begin
        len++;
        if (bus_addr !== a || (wr && bus_wdata !== d)) bad_stable = 1;
        if (req_ready) bad_ready = 1;
      end else begin
        early_done = 1;
      end
      bus_rvalid = (!wr && lat >= 0 && k == lat);
      bus_rdata  = bus_rvalid ? rp : ~rp;
      k++;
      @(negedge clk);
    end
    bus_rvalid = 1'b0;
    timed_out = !wr && (lat < 0 || lat >= TO);
    if (wr) exp_len = HOLD;
    else if (timed_out) exp_len = TO;
    else exp_len = ((lat > HOLD - 1) ? lat : HOLD - 1) + 1;
    chk(wr ? "R2 write strobe length" : (timed_out ? "R7 timeout strobe length"
                                                    : "R4 read strobe length"), 64'(len), 64'(exp_len));
    chk("R9 address/data held", 64'(bad_stable), 64'd0);
    chk("R1 ready low while busy", 64'(bad_ready), 64'd0);
    chk("R6 done right after strobe", 64'({done, early_done}), 64'b10);
    chk("R3 strobes low at done", 64'({bus_wr, bus_rd}), 64'd0);
    chk(timed_out ? "R7 error flag" : "R6 error flag", 64'(done_err), 64'(timed_out));
    if (wr) chk("R6 write rdata zero", 64'(done_rdata), 64'd0);
    else if (timed_out) chk("R7 rdata all ones", 64'(done_rdata), 64'hFFFF_FFFF);
    else chk("R5 read data", 64'(done_rdata), 64'(rp));
    while (!req_ready && g < 64) begin
      if (bus_wr || bus_rd) g = 100;
      g++;
      @(negedge clk);
    end
    chk("R3 idle gap cycles", 64'(g), 64'(GAP));
    chk("R6 done single pulse", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset strobes", 64'({bus_wr, bus_rd}), 64'd0);
    chk("R8 reset ready", 64'(req_ready), 64'd1);
    chk("R8 reset done", 64'({done, done_err}), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 no strobe without request", 64'({bus_wr, bus_rd}), 64'd0);
    end
    for (int i = 0; i < 16; i++)
      run_txn(1'b1, AW'(i * 16'h1111 + 3), pat(i + 100), 0, '0);
    for (int rep = 0; rep < 2; rep++)
      for (int lat = -1; lat <= TO + 1; lat++)
        run_txn(1'b0, AW'(16'h0400 + lat + 2 + rep * 32), '0, lat, pat(lat + 7 + rep * 13));
    for (int i = 0; i < 12; i++)
      run_txn(i[0], AW'(16'hA000 + i), pat(i + 40), i % (TO + 2), pat(i + 60));
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0BAD;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 reset mid-read strobes", 64'({bus_wr, bus_rd}), 64'd0);
    chk("R8 reset mid-read ready", 64'(req_ready), 64'd1);
    chk("R8 reset mid-read done", 64'({done, done_err}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", 64'({bus_wr, bus_rd}), 64'd0);
    run_txn(1'b1, 16'h1234, 32'hCAFE_F00D, 0, '0);
    run_txn(1'b0, 16'h4321, '0, 2, 32'h1357_9BDF);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule